// File: doc/BRIEF.md
# Beacon Synchronization Timer

This block keeps station time for a wireless MAC. A two-stage programmable prescaler turns the system clock into a microsecond tick and a coarser step tick. The microsecond tick advances a 64-bit time-synchronization counter. The step tick drives a beacon countdown and an ATIM window timer. One step is 64 microseconds, which is a sixteenth of a 1024 µs time unit.

Software sets the block up through a small register port with a 3-bit address, write and read strobes, and combinational read data. Through that port it sets the tick dividers, the beacon interval, the first-beacon preload and the ATIM window length. It also loads and reads the 64-bit counter. The block raises a one-cycle pulse when the beacon countdown expires and a one-cycle pulse when the ATIM window closes. A level shows while the ATIM window is open.

Top module: `bcn_sync_timer`

## Requirements
- R1: Register addresses are: 0 control, 1 prescaler, 2 beacon, 3 ATIM, 4 counter low, 5 counter high, 6 status. After reset the registers read as follows, and all three outputs are low:
  - control reads 0
  - prescaler reads 0x0000_4032
  - beacon reads 0x0640_0640
  - ATIM reads 0
  - both counter words read 0
  - status reads 0x0640_0000
- R2: Prescaler register bits [7:0] give the clock cycles per microsecond tick, and bits [15:8] give the microsecond ticks per step. The counter rises by one every [7:0] cycles.
- R3: Control bit 0 enables counting. While it is clear, the counter holds its value.
- R4: Control bits [2:1] hold the sync mode (0 disabled, 1 infrastructure, 2 ad-hoc/master). The field reads back as written.
- R5: A write to address 4 stages the low word. A write to address 5 loads {written high word, staged low word} into the counter, visible the next cycle, and clears both prescaler stages.
- R6: Reading address 4 returns the live low word and captures the high word. A later read of address 5 returns that captured high word, so a 64-bit read is consistent even when the low word has wrapped in between.
- R7: Setting control bit 3 (beacon enable) when it was clear loads the countdown from the preload, beacon register bits [31:16]. The first expiry pulse comes after that many steps.
- R8: At each expiry the countdown reloads from the interval, beacon register bits [15:0]. Later one-cycle pulses follow every interval steps.
- R9: While beacon enable is clear, no expiry pulse occurs. The countdown value, shown in status bits [31:16], holds.
- R10: Each expiry with a nonzero ATIM duration (ATIM register bits [15:0]) opens the window, shown in status bit 0 and on `atim_open_o`. The window closes after that many steps, with a one-cycle end pulse.
- R11: With an ATIM duration of 0, an expiry opens no window and produces no end pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid while re_i is high |
| bcn_pulse_o | output | 1 | One-cycle beacon expiry pulse |
| atim_pulse_o | output | 1 | One-cycle ATIM window end pulse |
| atim_open_o | output | 1 | ATIM window open |

## Verification
The bench times pulses to the exact cycle after a counter load has cleared the prescaler. A design that kept a stale prescaler phase, or counted the preload step as part of the enable cycle, would put the first beacon one tick early or late. The second beacon is checked against the interval rather than the preload, which catches a countdown that reloads from the wrong field. A split read across a low-word wrap catches a design that returns the live high word. Beacon disable and zero ATIM duration catch stray pulses and a window that opens with no length.

// File: rtl/bst_pkg.sv
package bst_pkg;
  localparam int DW    = 32;
  localparam int TSF_W = 2 * DW;
  localparam int AW    = 3;

  localparam logic [AW-1:0] ADDR_CTRL  = 3'd0;
  localparam logic [AW-1:0] ADDR_PRESC = 3'd1;
  localparam logic [AW-1:0] ADDR_BCN   = 3'd2;
  localparam logic [AW-1:0] ADDR_ATIM  = 3'd3;
  localparam logic [AW-1:0] ADDR_TSFLO = 3'd4;
  localparam logic [AW-1:0] ADDR_TSFHI = 3'd5;
  localparam logic [AW-1:0] ADDR_STAT  = 3'd6;

  localparam int CTRL_TSF_EN = 0;
  localparam int CTRL_SYNC_L = 1;
  localparam int CTRL_BCN_EN = 3;

  typedef enum logic [1:0] {
    SYNC_OFF   = 2'd0,
    SYNC_INFRA = 2'd1,
    SYNC_ADHOC = 2'd2
  } sync_mode_e;
endpackage

// File: rtl/bst_prescaler.sv
module bst_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [DIV_W-1:0] us_div_i,
  input  logic [DIV_W-1:0] step_div_i,
  output logic             us_tick_o,
  output logic             step_tick_o
);
  logic [DIV_W-1:0] us_cnt_q, step_cnt_q;
  logic [DIV_W-1:0] us_lim, step_lim;
  logic us_last, step_last;

  // a divider of 0 behaves as 1
  assign us_lim    = (us_div_i == '0)   ? '0 : us_div_i - 1'b1;
  assign step_lim  = (step_div_i == '0) ? '0 : step_div_i - 1'b1;
  assign us_last   = (us_cnt_q >= us_lim);
  assign step_last = (step_cnt_q >= step_lim);

  assign us_tick_o   = us_last & ~clear_i;
  assign step_tick_o = us_tick_o & step_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      us_cnt_q   <= '0;
      step_cnt_q <= '0;
    end else if (clear_i) begin
      us_cnt_q   <= '0;
      step_cnt_q <= '0;
    end else if (us_last) begin
      us_cnt_q   <= '0;
      step_cnt_q <= step_last ? '0 : step_cnt_q + 1'b1;
    end else begin
      us_cnt_q <= us_cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/bst_tsf.sv
module bst_tsf #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         en_i,
  input  logic         tick_i,
  output logic [W-1:0] tsf_o
);
  logic [W-1:0] tsf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              tsf_q <= '0;
    else if (load_i)          tsf_q <= load_val_i;
    else if (en_i && tick_i)  tsf_q <= tsf_q + 1'b1;
  end

  assign tsf_o = tsf_q;
endmodule

// File: rtl/bst_countdown.sv
module bst_countdown #(
  parameter int              W     = 16,
  parameter logic [W-1:0]    RST_V = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] preload_i,
  input  logic [W-1:0] reload_i,
  input  logic         en_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o,
  output logic         expire_now_o,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;
  logic         exp_q;

  assign expire_now_o = en_i & tick_i & ~start_i & (cnt_q <= W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= RST_V;
      exp_q <= 1'b0;
    end else begin
      exp_q <= expire_now_o;
      if (start_i)           cnt_q <= preload_i;
      else if (expire_now_o) cnt_q <= reload_i;
      else if (en_i && tick_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o    = cnt_q;
  assign expire_o = exp_q;
endmodule

// File: rtl/bst_atim.sv
module bst_atim #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         trig_i,
  input  logic [W-1:0] dur_i,
  input  logic         tick_i,
  output logic         open_o,
  output logic         end_o
);
  logic [W-1:0] cnt_q;
  logic         open_q, end_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      open_q <= 1'b0;
      end_q  <= 1'b0;
    end else begin
      end_q <= 1'b0;
      if (trig_i) begin
        // a new beacon restarts the window
        open_q <= (dur_i != '0);
        cnt_q  <= dur_i;
      end else if (open_q && tick_i) begin
        if (cnt_q <= W'(1)) begin
          open_q <= 1'b0;
          end_q  <= 1'b1;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign open_o = open_q;
  assign end_o  = end_q;
endmodule

// File: rtl/bcn_sync_timer.sv
module bcn_sync_timer
  import bst_pkg::*;
#(
  parameter int              DIV_W       = 8,
  parameter int              STEP_W      = 16,
  parameter logic [DIV_W-1:0] RST_US_DIV   = 8'd50,
  parameter logic [DIV_W-1:0] RST_STEP_DIV = 8'd64,
  parameter logic [STEP_W-1:0] RST_IVAL    = 16'd1600
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          bcn_pulse_o,
  output logic          atim_pulse_o,
  output logic          atim_open_o
);
  localparam int HI_W    = TSF_W - DW;
  localparam int PRESC_P = DW - 2 * DIV_W;
  localparam int STAT_P  = DW - STEP_W - 1;
  localparam int ATIM_P  = DW - STEP_W;

  logic             tsf_en, bcn_en;
  sync_mode_e       sync_q;
  logic [DIV_W-1:0] us_div_q, step_div_q;
  logic [STEP_W-1:0] ival_q, preload_q, atim_dur_q;
  logic [DW-1:0]    lo_stage_q;
  logic [HI_W-1:0]  hi_shadow_q;

  logic wr_ctrl, wr_presc, wr_bcn, wr_atim, wr_lo;
  logic tsf_load, bcn_start, rd_lo;
  logic [TSF_W-1:0] load_val, tsf;
  logic us_tick, step_tick;
  logic [STEP_W-1:0] bcn_cnt;
  logic bcn_now;

  assign wr_ctrl   = we_i && (addr_i == ADDR_CTRL);
  assign wr_presc  = we_i && (addr_i == ADDR_PRESC);
  assign wr_bcn    = we_i && (addr_i == ADDR_BCN);
  assign wr_atim   = we_i && (addr_i == ADDR_ATIM);
  assign wr_lo     = we_i && (addr_i == ADDR_TSFLO);
  assign tsf_load  = we_i && (addr_i == ADDR_TSFHI);
  assign rd_lo     = re_i && (addr_i == ADDR_TSFLO);
  assign bcn_start = wr_ctrl && wdata_i[CTRL_BCN_EN] && !bcn_en;
  assign load_val  = {wdata_i[HI_W-1:0], lo_stage_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tsf_en      <= 1'b0;
      bcn_en      <= 1'b0;
      sync_q      <= SYNC_OFF;
      us_div_q    <= RST_US_DIV;
      step_div_q  <= RST_STEP_DIV;
      ival_q      <= RST_IVAL;
      preload_q   <= RST_IVAL;
      atim_dur_q  <= '0;
      lo_stage_q  <= '0;
      hi_shadow_q <= '0;
    end else begin
      if (wr_ctrl) begin
        tsf_en <= wdata_i[CTRL_TSF_EN];
        bcn_en <= wdata_i[CTRL_BCN_EN];
        sync_q <= sync_mode_e'(wdata_i[CTRL_SYNC_L +: 2]);
      end
      if (wr_presc) begin
        us_div_q   <= wdata_i[DIV_W-1:0];
        step_div_q <= wdata_i[2*DIV_W-1:DIV_W];
      end
      if (wr_bcn) begin
        ival_q    <= wdata_i[STEP_W-1:0];
        preload_q <= wdata_i[DW-1:DW-STEP_W];
      end
      if (wr_atim) atim_dur_q <= wdata_i[STEP_W-1:0];
      if (wr_lo)   lo_stage_q <= wdata_i;
      if (rd_lo)   hi_shadow_q <= tsf[TSF_W-1:DW];
    end
  end

  bst_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (tsf_load),
    .us_div_i   (us_div_q),
    .step_div_i (step_div_q),
    .us_tick_o  (us_tick),
    .step_tick_o(step_tick)
  );

  bst_tsf #(.W(TSF_W)) u_tsf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tsf_load),
    .load_val_i(load_val),
    .en_i      (tsf_en),
    .tick_i    (us_tick),
    .tsf_o     (tsf)
  );

  bst_countdown #(.W(STEP_W), .RST_V(RST_IVAL)) u_bcn (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (bcn_start),
    .preload_i   (preload_q),
    .reload_i    (ival_q),
    .en_i        (bcn_en),
    .tick_i      (step_tick),
    .cnt_o       (bcn_cnt),
    .expire_now_o(bcn_now),
    .expire_o    (bcn_pulse_o)
  );

  bst_atim #(.W(STEP_W)) u_atim (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .trig_i(bcn_now),
    .dur_i (atim_dur_q),
    .tick_i(step_tick),
    .open_o(atim_open_o),
    .end_o (atim_pulse_o)
  );

  always_comb begin
    rdata_o = '0;
    if (re_i) begin
      unique case (addr_i)
        ADDR_CTRL:  rdata_o = DW'({bcn_en, sync_q, tsf_en});
        ADDR_PRESC: rdata_o = {{PRESC_P{1'b0}}, step_div_q, us_div_q};
        ADDR_BCN:   rdata_o = {preload_q, ival_q};
        ADDR_ATIM:  rdata_o = {{ATIM_P{1'b0}}, atim_dur_q};
        ADDR_TSFLO: rdata_o = tsf[DW-1:0];
        ADDR_TSFHI: rdata_o = hi_shadow_q;
        ADDR_STAT:  rdata_o = {bcn_cnt, {STAT_P{1'b0}}, atim_open_o};
        default:    rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/bst_checker.sv
module bst_checker #(
  parameter int TSF_W  = 64,
  parameter int STEP_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tsf_en,
  input logic              tsf_load,
  input logic [TSF_W-1:0]  load_val,
  input logic [TSF_W-1:0]  tsf,
  input logic              bcn_en,
  input logic              bcn_start,
  input logic [STEP_W-1:0] bcn_cnt,
  input logic              bcn_pulse_o,
  input logic              atim_pulse_o,
  input logic              atim_open_o
);
  AST_TSF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tsf_en && !tsf_load) |=> $stable(tsf)); // R3

  AST_TSF_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tsf_load |=> (tsf == $past(load_val))); // R5

  AST_PULSE_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bcn_pulse_o |-> $past(bcn_en)); // R9

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bcn_en && !bcn_start) |=> $stable(bcn_cnt)); // R9

  AST_ATIM_OPEN_AT_BCN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(atim_open_o) |-> bcn_pulse_o); // R10

  AST_ATIM_END_CLOSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    atim_pulse_o |-> !atim_open_o); // R10
endmodule

bind bcn_sync_timer bst_checker #(.TSF_W(bst_pkg::TSF_W), .STEP_W(STEP_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tsf_en      (tsf_en),
  .tsf_load    (tsf_load),
  .load_val    (load_val),
  .tsf         (tsf),
  .bcn_en      (bcn_en),
  .bcn_start   (bcn_start),
  .bcn_cnt     (bcn_cnt),
  .bcn_pulse_o (bcn_pulse_o),
  .atim_pulse_o(atim_pulse_o),
  .atim_open_o (atim_open_o)
);

// File: tb/bcn_sync_timer_tb.sv
module bcn_sync_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        bcn_p, atim_p, atim_open;

  int tests = 0, fails = 0;
  int cyc = 0;
  bit done = 0;

  int bcn_n = 0, atim_n = 0;
  int bcn_cyc [0:1023];
  int atim_cyc[0:1023];
  bit open_at [0:1023];

  always #2 clk = ~clk;

  bcn_sync_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .re_i(re), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .bcn_pulse_o(bcn_p),
    .atim_pulse_o(atim_p), .atim_open_o(atim_open)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (bcn_p && bcn_n < 1024) begin
      bcn_cyc[bcn_n] = cyc;
      open_at[bcn_n] = atim_open;
      bcn_n++;
    end
    if (atim_p && atim_n < 1024) begin
      atim_cyc[atim_n] = cyc;
      atim_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    re = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    re = 1'b0;
  endtask

  function automatic longint exp_tsf(input longint base, input int k, input int u);
    return base + longint'(k / u);
  endfunction

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic arm(input int u, input int d, input int ival, input int pre,
                     input int dur, output int e);
    wr(3'd0, 32'h1);
    wr(3'd1, (d << 8) | u);
    wr(3'd2, (pre << 16) | ival);
    wr(3'd3, dur);
    wr(3'd4, 32'h0);
    wr(3'd5, 32'h0);
    e = cyc;
    wr(3'd0, 32'h9);
  endtask

  initial begin
    logic [31:0] v, v2;
    int e, b0, a0, m, to;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(!bcn_p && !atim_p && !atim_open, "R1 outputs", {bcn_p, atim_p, atim_open}, 0);
    rd(3'd0, v); chk(v == 32'h0, "R1 ctrl", v, 32'h0);
    rd(3'd1, v); chk(v == 32'h4032, "R1 presc", v, 32'h4032);
    rd(3'd2, v); chk(v == 32'h0640_0640, "R1 bcn", v, 32'h0640_0640);
    rd(3'd3, v); chk(v == 32'h0, "R1 atim", v, 0);
    rd(3'd4, v); chk(v == 32'h0, "R1 tsf lo", v, 0);
    rd(3'd5, v); chk(v == 32'h0, "R1 tsf hi", v, 0);
    rd(3'd6, v); chk(v == 32'h0640_0000, "R1 stat", v, 32'h0640_0000);

    // R4 sync mode readback
    wr(3'd0, 32'h4); rd(3'd0, v); chk(v == 32'h4, "R4 adhoc", v, 32'h4);
    wr(3'd0, 32'h2); rd(3'd0, v); chk(v == 32'h2, "R4 infra", v, 32'h2);

    // R2/R5 counter rate and load, random dividers
    for (int it = 0; it < 6; it++) begin
      int u, k;
      logic [31:0] lo, hi;
      u  = 1 + ($urandom % 5);
      k  = 10 + ($urandom % 190);
      lo = $urandom & 32'h3fff_ffff;
      hi = $urandom;
      wr(3'd0, 32'h1);
      wr(3'd1, (($urandom % 8) << 8) | u);
      rd(3'd1, v); chk(v[7:0] == u[7:0], "R2 presc readback", v[7:0], u);
      wr(3'd4, lo);
      wr(3'd5, hi);
      e = cyc;
      wait_until(e + k);
      rd(3'd4, v);
      chk(v == 32'(exp_tsf(longint'(lo), k, u)), "R2 R5 tsf lo", v, exp_tsf(longint'(lo), k, u));
      rd(3'd5, v);
      chk(v == hi, "R5 tsf hi", v, hi);
    end

    // R3 counting disabled holds
    wr(3'd0, 32'h0);
    rd(3'd4, v);
    repeat (40) @(negedge clk);
    rd(3'd4, v2);
    chk(v2 == v, "R3 hold", v2, v);

    // R6 consistent split read across low-word wrap
    wr(3'd0, 32'h1);
    wr(3'd1, 32'h0101);
    wr(3'd4, 32'hFFFF_FFF0);
    wr(3'd5, 32'h7);
    e = cyc;
    wait_until(e + 15);
    rd(3'd4, v);  chk(v == 32'hFFFF_FFFF, "R6 lo before wrap", v, 32'hFFFF_FFFF);
    repeat (5) @(negedge clk);
    rd(3'd5, v);  chk(v == 32'h7, "R6 captured hi", v, 32'h7);
    m = cyc;
    rd(3'd4, v);  chk(v == 32'(m - e - 16), "R6 lo after wrap", v, m - e - 16);
    rd(3'd5, v);  chk(v == 32'h8, "R6 hi after wrap", v, 32'h8);

    // R7/R8/R10 beacon and ATIM timing, random configs
    for (int it = 0; it < 4; it++) begin
      int u, d, ival, pre, dur;
      u = 2 + ($urandom % 2); d = 1 + ($urandom % 3);
      ival = 2 + ($urandom % 5); pre = 1 + ($urandom % 5);
      dur = 1 + ($urandom % (ival - 1));
      m = u * d;
      b0 = bcn_n; a0 = atim_n;
      arm(u, d, ival, pre, dur, e);
      to = 0;
      while ((bcn_n < b0 + 2 || atim_n < a0 + 2) && to < 3000) begin
        @(negedge clk); to++;
      end
      chk(bcn_n >= b0 + 2 && atim_n >= a0 + 2, "R8 pulses seen", bcn_n - b0, 2);
      chk(bcn_cyc[b0] == e + pre * m, "R7 first expiry", bcn_cyc[b0], e + pre * m);
      chk(bcn_cyc[b0+1] - bcn_cyc[b0] == ival * m, "R8 period",
          bcn_cyc[b0+1] - bcn_cyc[b0], ival * m);
      chk(open_at[b0] == 1'b1, "R10 window open", open_at[b0], 1);
      chk(atim_cyc[a0] - bcn_cyc[b0] == dur * m, "R10 window length",
          atim_cyc[a0] - bcn_cyc[b0], dur * m);
      // R9 disable holds countdown and stops pulses
      wr(3'd0, 32'h1);
      repeat (ival * m * 2) @(negedge clk);
      b0 = bcn_n;
      rd(3'd6, v);
      repeat (ival * m * 3) @(negedge clk);
      rd(3'd6, v2);
      chk(bcn_n == b0, "R9 no pulse", bcn_n - b0, 0);
      chk(v2[31:16] == v[31:16], "R9 count hold", v2[31:16], v[31:16]);
    end

    // R11 zero ATIM duration
    b0 = bcn_n; a0 = atim_n;
    arm(2, 2, 3, 2, 0, e);
    to = 0;
    while (bcn_n < b0 + 2 && to < 3000) begin @(negedge clk); to++; end
    repeat (12) @(negedge clk);
    chk(bcn_n >= b0 + 2, "R11 beacons", bcn_n - b0, 2);
    chk(atim_n == a0, "R11 no end pulse", atim_n - a0, 0);
    chk(open_at[b0] == 1'b0 && open_at[b0+1] == 1'b0 && !atim_open, "R11 no window",
        open_at[b0+1], 0);
    wr(3'd0, 32'h0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule